// File: doc/BRIEF.md
# Serial Seven-Segment Chain Driver

This block sends the segment patterns for a row of seven-segment digits down a two-wire serial link: one data line and one shift clock. Off-chip, each digit has its own 8-bit shift register. The registers are cascaded, so the top bit of one register feeds the data input of the next. One transfer clocks the whole frame through the chain. When it ends, every digit holds its own byte.

A single-cycle `start_i` pulse captures all digit codes from `code_i`. A down-counter is then preset to the frame length. It drops by one on each shift-clock period, and the transfer ends when it reaches zero. `busy_o` is high for the whole transfer, and `done_o` pulses for one cycle when it finishes.

A parameter selects whether each digit field holds a raw segment byte or a hex digit that the block converts to a pattern. A second parameter inverts every bit so that common-cathode displays can be driven.

Top module: `segchain_tx`

## Requirements
- R1: After an accepted start, the bits sampled on the rising edges of `sclk_o` are the digit bytes in order: digit 0 (`code_i[7:0]`) first, then digit 1 and so on. Each byte goes out with bit 7 first.
- R2: A start is accepted only when `busy_o` is low. `busy_o` rises in the next cycle and stays high for exactly DIGITS*8*CLK_DIV cycles. Each shift-clock period lasts CLK_DIV system cycles, with the clock low in the first half and high in the second half.
- R3: `sdata_o` never changes in the cycle in which `sclk_o` rises, so data is held for at least one system cycle before each rising edge.
- R4: `sclk_o` is low whenever `busy_o` is low.
- R5: A start pulse that arrives while `busy_o` is high is ignored: the frame being sent and its length do not change.
- R6: `done_o` is high for exactly one cycle. That cycle is the first one in which `busy_o` is low again after a transfer.
- R7: While reset is asserted and right after it, `busy_o`, `done_o`, `sclk_o` and `sdata_o` are all 0.
- R8: With COMMON_CATHODE=1, every bit of every byte is inverted before it is sent, so a 1 lights a segment. With COMMON_CATHODE=0, bytes are sent as given, so a 0 lights a segment.
- R9: With HEX_IN=1, the low nibble of each digit field is converted to a common-anode pattern, before the polarity step of R8. In that pattern bit 7 down to bit 0 drive segments h g f e d c b a, with h being the decimal point. Hex A gives 88H. The decimal point is lit when any bit of the upper nibble is set.
- R10: Each transfer produces exactly DIGITS*8 rising edges on `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to send a frame |
| code_i | input | DIGITS*8 | Digit fields; digit k occupies bits 8k+7 down to 8k |
| sdata_o | output | 1 | Serial segment data into the chain |
| sclk_o | output | 1 | Shift clock for the chain; idles low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A corrupted shift register shows up as a wrong bit in the captured stream, within the same frame. A miscounting bit counter shows up in two ways: the busy window is too long or too short, and the number of shift-clock rising edges is not 32, both visible when that frame ends. A timer phase error moves the rising edge onto a data change or breaks the high/low halves, and the setup check reports it on the first bad edge. A start that leaks through while busy replaces the frame contents, and the mismatch appears in that frame's captured bytes.

// File: rtl/segchain_pkg.sv
package segchain_pkg;

   localparam int SEG_BITS = 8;

   // Lit pattern for one hex digit, bit 6..0 = g f e d c b a, 1 = segment on.
   function automatic logic [6:0] hex_lit(input logic [3:0] nib);
      logic [6:0] r;
      case (nib)
         4'h0: r = 7'h3F;
         4'h1: r = 7'h06;
         4'h2: r = 7'h5B;
         4'h3: r = 7'h4F;
         4'h4: r = 7'h66;
         4'h5: r = 7'h6D;
         4'h6: r = 7'h7D;
         4'h7: r = 7'h07;
         4'h8: r = 7'h7F;
         4'h9: r = 7'h6F;
         4'hA: r = 7'h77;
         4'hB: r = 7'h7C;
         4'hC: r = 7'h39;
         4'hD: r = 7'h5E;
         4'hE: r = 7'h79;
         default: r = 7'h71;
      endcase
      return r;
   endfunction

   // Common-anode byte: bit 7 = decimal point, 0 = lit.
   function automatic logic [SEG_BITS-1:0] hex_to_anode(input logic [3:0] nib,
                                                         input logic       dp_on);
      return ~{dp_on, hex_lit(nib)};
   endfunction

endpackage

// File: rtl/seg_code_map.sv
module seg_code_map
   import segchain_pkg::*;
#(
   parameter int DIGITS         = 4,
   parameter bit HEX_IN         = 1'b0,
   parameter bit COMMON_CATHODE = 1'b0,
   localparam int FRAME_W       = DIGITS * SEG_BITS
) (
   input  logic [FRAME_W-1:0] code_i,
   output logic [FRAME_W-1:0] frame_o
);

   // Digit 0 lands in the top byte of the frame so it leaves first.
   for (genvar k = 0; k < DIGITS; k++) begin : g_digit
      logic [SEG_BITS-1:0] raw;
      logic [SEG_BITS-1:0] anode;

      assign raw = code_i[k*SEG_BITS +: SEG_BITS];

      if (HEX_IN) begin : g_hex
         assign anode = hex_to_anode(raw[3:0], |raw[7:4]);
      end else begin : g_raw
         assign anode = raw;
      end

      if (COMMON_CATHODE) begin : g_cathode
         assign frame_o[(DIGITS-1-k)*SEG_BITS +: SEG_BITS] = ~anode;
      end else begin : g_anode
         assign frame_o[(DIGITS-1-k)*SEG_BITS +: SEG_BITS] = anode;
      end
   end

endmodule

// File: rtl/seg_sclk_timer.sv
module seg_sclk_timer #(
   parameter int CLK_DIV   = 4,
   localparam int HALF     = CLK_DIV / 2,
   localparam int PH_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic busy_i,
   output logic sclk_o,
   output logic shift_o
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);

   logic [PH_W-1:0] phase_q;
   logic            sclk_q;

   // End of a shift-clock period: falling edge and next data bit.
   assign shift_o = busy_i && (phase_q == PH_LAST);
   assign sclk_o  = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         sclk_q  <= 1'b0;
      end else if (load_i) begin
         phase_q <= '0;
         sclk_q  <= 1'b0;
      end else if (busy_i) begin
         if (shift_o) begin
            phase_q <= '0;
            sclk_q  <= 1'b0;
         end else begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == PH_RISE) sclk_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/seg_bit_counter.sv
module seg_bit_counter #(
   parameter int TOTAL = 32,
   localparam int CNT_W = $clog2(TOTAL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic shift_i,
   output logic load_o,
   output logic busy_o,
   output logic done_o
);

   logic [CNT_W-1:0] left_q;
   logic             busy_q;
   logic             done_q;

   assign load_o = start_i && !busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (load_o) begin
         left_q <= CNT_W'(TOTAL);
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (shift_i && busy_q) begin
         left_q <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            done_q <= 1'b0;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

endmodule

// File: rtl/seg_frame_shifter.sv
module seg_frame_shifter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic [WIDTH-1:0] frame_i,
   output logic             sdata_o
);

   logic [WIDTH-1:0] sh_q;

   assign sdata_o = sh_q[WIDTH-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= frame_i;
      end else if (shift_i) begin
         sh_q <= {sh_q[WIDTH-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/segchain_tx.sv
module segchain_tx
   import segchain_pkg::*;
#(
   parameter int DIGITS         = 4,
   parameter int CLK_DIV        = 4,
   parameter bit HEX_IN         = 1'b0,
   parameter bit COMMON_CATHODE = 1'b0,
   localparam int FRAME_W       = DIGITS * SEG_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] code_i,
   output logic               sdata_o,
   output logic               sclk_o,
   output logic               busy_o,
   output logic               done_o
);

   if (DIGITS < 1) begin : g_bad_digits
      $error("segchain_tx: DIGITS must be at least 1");
   end
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("segchain_tx: CLK_DIV must be even and at least 2");
   end

   logic [FRAME_W-1:0] frame;
   logic               load;
   logic               shift;
   logic               busy;

   seg_code_map #(
      .DIGITS         (DIGITS),
      .HEX_IN         (HEX_IN),
      .COMMON_CATHODE (COMMON_CATHODE)
   ) u_map (
      .code_i  (code_i),
      .frame_o (frame)
   );

   seg_bit_counter #(
      .TOTAL (FRAME_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .shift_i (shift),
      .load_o  (load),
      .busy_o  (busy),
      .done_o  (done_o)
   );

   seg_sclk_timer #(
      .CLK_DIV (CLK_DIV)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .busy_i  (busy),
      .sclk_o  (sclk_o),
      .shift_o (shift)
   );

   seg_frame_shifter #(
      .WIDTH (FRAME_W)
   ) u_shf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (shift),
      .frame_i (frame),
      .sdata_o (sdata_o)
   );

   assign busy_o = busy;

endmodule

// File: rtl/segchain_tx_chk.sv
module segchain_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic sclk_o,
   input logic sdata_o
);

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sclk_o); // R4

   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(sdata_o)); // R3

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R6

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i)); // R2

endmodule

bind segchain_tx segchain_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .sclk_o  (sclk_o),
   .sdata_o (sdata_o)
);

// File: tb/segchain_tx_tb_top.sv
module segchain_tx_tb_top;

   localparam int DIGITS = 4;
   localparam int DIV    = 4;
   localparam int NB     = DIGITS * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NB-1:0] code = '0;

   logic sd_a, sc_a, bz_a, dn_a;
   logic sd_b, sc_b, bz_b, dn_b;

   always #5 clk = ~clk;

   segchain_tx #(.DIGITS(DIGITS), .CLK_DIV(DIV), .HEX_IN(1'b0), .COMMON_CATHODE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
      .sdata_o(sd_a), .sclk_o(sc_a), .busy_o(bz_a), .done_o(dn_a));

   segchain_tx #(.DIGITS(DIGITS), .CLK_DIV(DIV), .HEX_IN(1'b1), .COMMON_CATHODE(1'b1)) dut_hex_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
      .sdata_o(sd_b), .sclk_o(sc_b), .busy_o(bz_b), .done_o(dn_b));

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Serial capture on rising shift-clock edges, sampled at negedge.
   logic          clr = 1'b0;
   logic [NB-1:0] cap_a = '0, cap_b = '0;
   int            rise_a = 0, rise_b = 0;
   logic          ps_a = 1'b0, ps_b = 1'b0;

   always @(negedge clk) begin
      ps_a <= sc_a;
      ps_b <= sc_b;
      if (clr) begin
         cap_a <= '0; cap_b <= '0; rise_a <= 0; rise_b <= 0;
      end else begin
         if (sc_a && !ps_a) begin cap_a <= {cap_a[NB-2:0], sd_a}; rise_a <= rise_a + 1; end
         if (sc_b && !ps_b) begin cap_b <= {cap_b[NB-2:0], sd_b}; rise_b <= rise_b + 1; end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] lit7(input logic [3:0] n);
      case (n)
         4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
         4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
         4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
         4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
      endcase
   endfunction

   // R1: digit 0 first, each byte MSB first.
   function automatic logic [NB-1:0] exp_raw(input logic [NB-1:0] c);
      logic [NB-1:0] r;
      for (int k = 0; k < DIGITS; k++) r[(DIGITS-1-k)*8 +: 8] = c[k*8 +: 8];
      return r;
   endfunction

   // R9 + R8: anode pattern from hex nibble, then inverted for cathode.
   function automatic logic [NB-1:0] exp_hex(input logic [NB-1:0] c);
      logic [NB-1:0] r;
      logic [7:0]    an;
      for (int k = 0; k < DIGITS; k++) begin
         an = ~{|c[k*8+4 +: 4], lit7(c[k*8 +: 4])};
         r[(DIGITS-1-k)*8 +: 8] = ~an;
      end
      return r;
   endfunction

   task automatic run_frame(input logic [NB-1:0] c, input bit poke);
      int cnt;
      @(posedge clk); #2;
      start = 1'b1; code = c; clr = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      @(negedge clk);
      chk("R2 busy after start", 64'(bz_a), 64'd1);
      cnt = 0;
      while (bz_a === 1'b1 && cnt < 10*NB*DIV) begin
         cnt++;
         #2;
         if (cnt == 1) clr = 1'b0;
         if (poke && cnt == 40) begin start = 1'b1; code = ~c; end
         if (poke && cnt == 41) begin start = 1'b0; code = c; end
         @(negedge clk);
      end
      chk("R2 busy length", 64'(cnt), 64'(NB*DIV));
      chk("R6 done at end", 64'(dn_a), 64'd1);
      chk("R6 done at end hex", 64'(dn_b), 64'd1);
      chk("R2 busy hex ended", 64'(bz_b), 64'd0);
      chk(poke ? "R5 stream after ignored start" : "R1 stream", 64'(cap_a), 64'(exp_raw(c)));
      chk("R8 R9 hex cathode stream", 64'(cap_b), 64'(exp_hex(c)));
      chk("R10 rising edges", 64'(rise_a), 64'(NB));
      chk("R4 sclk idle low", 64'(sc_a), 64'd0);
      @(negedge clk);
      chk("R6 done one cycle", 64'(dn_a), 64'd0);
      chk("R4 sclk idle low later", 64'(sc_a), 64'd0);
   endtask

   initial begin
      void'($urandom(32'h5E65));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 busy in reset", 64'(bz_a), 64'd0);
      chk("R7 done in reset", 64'(dn_a), 64'd0);
      chk("R7 sclk in reset", 64'(sc_a), 64'd0);
      chk("R7 sdata in reset", 64'(sd_a), 64'd0);
      @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R7 busy after reset", 64'(bz_a), 64'd0);
      chk("R7 sdata after reset", 64'(sd_a), 64'd0);

      // Directed: A pattern 88H in digit 0, all-on / all-off bytes.
      run_frame({8'h01, 8'h80, 8'hFF, 8'h88}, 1'b0);
      // Directed hex: digits A, 6 with dp, 0, F.
      run_frame({8'h0F, 8'h00, 8'h16, 8'h0A}, 1'b0);
      chk("R9 hex A cathode byte", 64'(cap_b[NB-1 -: 8]), 64'h77);
      chk("R9 hex 6 with dp", 64'(cap_b[NB-9 -: 8]), 64'hFD);
      // Directed: start while busy is ignored.
      run_frame({8'hA5, 8'h3C, 8'h00, 8'hF0}, 1'b1);

      for (int i = 0; i < 24; i++) begin
         logic [NB-1:0] rc;
         rc = NB'($urandom());
         run_frame(rc, (i % 5) == 2);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule